// File: doc/BRIEF.md
# Sequential Booth Multiplier and Shift-Subtract Divider

This unit computes either a product or a quotient/remainder pair of two 32-bit operands over many clock cycles. One iteration runs per cycle. Both operations use the same state machine, the same double-width working register and the same operand register. A mode input picks the operation and a second input says whether the operands are two's complement or unsigned.

Multiplication uses radix-2 Booth recoding. The multiplier bit is paired with the bit shifted out in the previous step to choose whether the multiplicand is added, subtracted or skipped. The partial product then shifts right arithmetically. Division works on magnitudes. A shifting register holds the partial remainder in its upper part and collects the quotient bits in its lower part. The signs are applied in a final cycle, which also registers the result and a 4-bit status word and pulses the done flag.

An operation starts when start_i is high while en_i is high and the unit is idle. The result on y_o and status_o stays stable until the next completion.

Top module: `seq_muldiv`

## Requirements
- R1: With op_div_i=0 and signed_i=0, y_o is the 64-bit unsigned product of a_i and b_i, with y_o[64]=0.
- R2: With op_div_i=0 and signed_i=1, y_o is the two's-complement product of a_i and b_i, sign-extended to 65 bits.
- R3: status_o is {C,V,Z,N} (bit 3 down to bit 0). After a multiply, N=y_o[64] and Z=1 when the product is zero. V=1 when the product does not fit in 32 bits, judged as signed or unsigned to match signed_i. C=0.
- R4: Counting the rising edge that samples start_i as edge 1, done_o is first high after edge 35 for a multiply and after edge 34 for a divide.
- R5: done_o is high for exactly one cycle per operation. y_o and status_o change only in the cycle where done_o rises, and they hold afterwards.
- R6: With op_div_i=1 and signed_i=0, y_o[31:0] is the quotient a_i/b_i, y_o[63:32] is the remainder, and y_o[64]=0.
- R7: With op_div_i=1 and signed_i=1, the quotient is truncated toward zero and the remainder takes the sign of the dividend a_i.
- R8: After a divide, N equals quotient bit 31 in signed mode and is 0 in unsigned mode. Z=1 when the quotient is zero. V=1 only for signed -2^31 divided by -1. C=1 when the divisor is zero.
- R9: A zero divisor gives a quotient of all ones and a remainder equal to a_i, and done_o arrives with the normal latency.
- R10: start_i is ignored while an operation is in progress. The running operation finishes with its own operands and its normal latency.
- R11: start_i is ignored while en_i is low, so no done_o follows and y_o is unchanged.
- R12: rst_ni low asynchronously clears y_o, status_o and done_o and aborts any operation. After release, a new operation runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request |
| en_i | input | 1 | Qualifies start_i |
| op_div_i | input | 1 | 1 = divide, 0 = multiply |
| signed_i | input | 1 | 1 = two's-complement operands |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| y_o | output | 65 | Product, or {0, remainder, quotient} |
| status_o | output | 4 | {C,V,Z,N} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Multiplies are run with mixed signs, zero operands, all-ones operands and the most negative value. In signed mode, all-ones separates correct Booth sign handling from an unsigned treatment. The most negative value times itself exposes a missing guard bit in the accumulator.

Divides cover every sign combination with a nonzero remainder, which checks the direction of truncation and the sign of the remainder. They also cover a divisor larger than the dividend, a zero divisor in both modes, and the single signed overflow case.

Further runs place a second start pulse in the middle of an operation, pulse start with en_i low, and assert reset partway through a divide. These show that only an idle, enabled request launches work.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} md_state_e;
  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } md_status_t;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [CW-1:0] last_i,
  output md_state_e     state_o,
  output logic [CW-1:0] cnt_o
);
  md_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: if (cnt_q == last_i) state_q <= ST_FIN;
                else cnt_q <= cnt_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q <= last_i));
  p_run_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != last_i) |=> (state_q == ST_RUN));
endmodule

// File: rtl/booth_step.sv
module booth_step #(
  parameter int unsigned W = 32
) (
  input  logic [W+1:0] hi_i,
  input  logic [W:0]   lo_i,
  input  logic         q1_i,
  input  logic [W+1:0] m_i,
  output logic [W+1:0] hi_o,
  output logic [W:0]   lo_o,
  output logic         q1_o
);
  logic [W+1:0] sum;

  always_comb begin
    unique case ({lo_i[0], q1_i})
      2'b01:   sum = hi_i + m_i;
      2'b10:   sum = hi_i - m_i;
      default: sum = hi_i;
    endcase
    {hi_o, lo_o} = {sum[W+1], sum, lo_i[W:1]};
    q1_o = lo_i[0];
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   rem_sh;
  logic         ge;
  logic [W-1:0] sub;

  always_comb begin
    rem_sh = {rem_i, quo_i[W-1]};
    ge     = rem_sh >= {1'b0, d_i};
    sub    = rem_sh[W-1:0] - d_i;   // exact when ge
    rem_o  = ge ? sub : rem_sh[W-1:0];
    quo_o  = {quo_i[W-2:0], ge};
  end
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import muldiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         en_i,
  input  logic         op_div_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [2*W:0] y_o,
  output logic [3:0]   status_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W + 1);

  md_state_e     state;
  logic [CW-1:0] cnt, last;
  logic          launch;

  logic [W+1:0] hi_q, m_q, hi_b;
  logic [W:0]   lo_q, lo_b;
  logic         q1_q, q1_b;
  logic [W-1:0] rem_n, quo_n;
  logic         div_q, sgn_q, negq_q, negr_q, dz_q;
  logic [2*W:0] y_q, y_n;
  md_status_t   st_q, st_n;
  logic         done_q;

  assign launch = start_i && en_i;
  assign last   = div_q ? CW'(W - 1) : CW'(W);

  muldiv_ctrl #(.CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .launch_i(launch), .last_i(last),
    .state_o(state), .cnt_o(cnt)
  );

  booth_step #(.W(W)) u_booth (
    .hi_i(hi_q), .lo_i(lo_q), .q1_i(q1_q), .m_i(m_q),
    .hi_o(hi_b), .lo_o(lo_b), .q1_o(q1_b)
  );

  div_step #(.W(W)) u_div (
    .rem_i(hi_q[W-1:0]), .quo_i(lo_q[W-1:0]), .d_i(m_q[W-1:0]),
    .rem_o(rem_n), .quo_o(quo_n)
  );

  // final sign fix-up and flags
  logic [W-1:0] qf, rf;
  always_comb begin
    qf = negq_q ? -lo_q[W-1:0] : lo_q[W-1:0];
    rf = negr_q ? -hi_q[W-1:0] : hi_q[W-1:0];
    if (div_q) begin
      y_n  = {1'b0, rf, qf};
      st_n = '{c: dz_q,
               v: sgn_q && !dz_q && !negq_q && lo_q[W-1],
               z: (qf == '0),
               n: sgn_q && qf[W-1]};
    end else begin
      y_n  = {hi_q[W-1:0], lo_q};
      st_n = '{c: 1'b0,
               v: sgn_q ? (y_n[2*W-1:W-1] != '0 && y_n[2*W-1:W-1] != '1)
                        : (y_n[2*W-1:W] != '0),
               z: (y_n == '0),
               n: y_n[2*W]};
    end
  end

  logic [W-1:0] a_mag, b_mag;
  assign a_mag = (signed_i && a_i[W-1]) ? -a_i : a_i;
  assign b_mag = (signed_i && b_i[W-1]) ? -b_i : b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0; lo_q <= '0; q1_q <= 1'b0; m_q <= '0;
      div_q <= 1'b0; sgn_q <= 1'b0; negq_q <= 1'b0; negr_q <= 1'b0; dz_q <= 1'b0;
      y_q <= '0; st_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (launch) begin
          div_q  <= op_div_i;
          sgn_q  <= signed_i;
          hi_q   <= '0;
          q1_q   <= 1'b0;
          dz_q   <= (b_i == '0);
          negq_q <= signed_i && (a_i[W-1] ^ b_i[W-1]) && (b_i != '0);
          negr_q <= signed_i && a_i[W-1];
          if (op_div_i) begin
            lo_q <= {1'b0, a_mag};
            m_q  <= {2'b00, b_mag};
          end else begin
            lo_q <= {signed_i && b_i[W-1], b_i};
            m_q  <= {{2{signed_i && a_i[W-1]}}, a_i};
          end
        end
        ST_RUN: if (div_q) begin
          hi_q <= {2'b00, rem_n};
          lo_q <= {1'b0, quo_n};
        end else begin
          hi_q <= hi_b; lo_q <= lo_b; q1_q <= q1_b;
        end
        default: begin
          y_q    <= y_n;
          st_q   <= st_n;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign y_o      = y_q;
  assign status_o = st_q;
  assign done_o   = done_q;

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(y_o) && $stable(status_o)));
  p_divzero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_q && dz_q) |-> (y_o[W-1:0] == '1 && status_o[3]));
  p_mul_nocarry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_q) |-> !status_o[3]);
endmodule

// File: tb/seq_muldiv_tb_top.sv
`timescale 1ns/1ps
module seq_muldiv_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, en_i = 1'b1, op_div_i = 1'b0, signed_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [64:0] y_o;
  logic [3:0]  status_o;
  logic        done_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  seq_muldiv dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input bit dv, input bit sg, input logic [31:0] a, input logic [31:0] b,
                       output logic [64:0] y, output logic [3:0] st);
    logic [63:0] p; logic [31:0] q, r; longint sa, sb;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    if (!dv) begin
      p = sg ? 64'(sa * sb) : {32'b0, a} * {32'b0, b};
      y = sg ? {p[63], p} : {1'b0, p};
      st = {1'b0, sg ? (p != {{32{p[31]}}, p[31:0]}) : (p[63:32] != 0), p == 0, y[64]};
    end else begin
      if (b == 0) begin q = '1; r = a; end
      else if (sg) begin q = 32'(sa / sb); r = 32'(sa % sb); end
      else begin q = a / b; r = a % b; end
      y = {1'b0, r, q};
      st = {b == 0, sg && a == 32'h8000_0000 && b == '1, q == 0, sg && q[31]};
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8 R9 checked per operation
  task automatic run_op(input bit dv, input bit sg, input logic [31:0] a, input logic [31:0] b,
                        input string req, input int mid_start = 0);
    logic [64:0] ye; logic [3:0] se; int cyc = 0; logic [64:0] yh;
    model(dv, sg, a, b, ye, se);
    @(negedge clk_i);
    op_div_i = dv; signed_i = sg; a_i = a; b_i = b; start_i = 1'b1; en_i = 1'b1;
    do begin
      @(posedge clk_i); cyc++;
      @(negedge clk_i);
      start_i = (mid_start != 0 && cyc == mid_start);
      if (start_i) begin op_div_i = ~dv; a_i = 32'h1234_5678; b_i = 32'h3; end
    end while (!done_o && cyc < 100);
    start_i = 1'b0;
    chk(cyc == (dv ? 34 : 35), {req, " R4 latency"}, 65'(cyc), 65'(dv ? 34 : 35));
    chk(y_o === ye, {req, " result"}, y_o, ye);
    chk(status_o === se, {req, " status"}, 65'(status_o), 65'(se));
    yh = y_o;
    @(negedge clk_i);
    chk(!done_o && y_o === yh, {req, " R5 pulse/hold"}, {done_o, y_o[63:0]}, {1'b0, yh[63:0]});
  endtask

  task automatic t_reset_state();
    chk(y_o === '0 && status_o === '0 && done_o === 1'b0, "R12 reset state",
        {done_o, y_o[63:0]}, '0);
  endtask

  task automatic t_enable_low();
    logic [64:0] yh; bit seen = 0;
    yh = y_o;
    @(negedge clk_i);
    en_i = 1'b0; start_i = 1'b1; op_div_i = 1'b0; a_i = 5; b_i = 6;
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < 40; i++) begin @(negedge clk_i); if (done_o) seen = 1; end
    en_i = 1'b1;
    chk(!seen && y_o === yh, "R11 start ignored with en low", {seen, y_o[63:0]}, {1'b0, yh[63:0]});
  endtask

  task automatic t_reset_abort();
    @(negedge clk_i);
    op_div_i = 1'b1; signed_i = 1'b0; a_i = 1000; b_i = 7; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0; #2;
    chk(y_o === '0 && status_o === '0 && !done_o, "R12 async abort", {done_o, y_o[63:0]}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    run_op(1, 0, 1000, 7, "R12 after reset R6");
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5; t_reset_state();
    repeat (2) @(negedge clk_i); rst_ni = 1'b1;
    run_op(0, 0, 32'd12345, 32'd6789, "R1 unsigned mul");
    run_op(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 R3 unsigned max mul");
    run_op(0, 0, 32'd0, 32'hDEAD_BEEF, "R3 zero product");
    run_op(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 signed -1*-1");
    run_op(0, 1, 32'hFFFF_FF9C, 32'd37, "R2 R3 signed neg*pos");
    run_op(0, 1, 32'h8000_0000, 32'h8000_0000, "R2 R3 signed min*min");
    run_op(0, 1, 32'h0000_7FFF, 32'h0000_7FFF, "R2 signed fits");
    run_op(1, 0, 32'd1000003, 32'd97, "R6 unsigned div");
    run_op(1, 0, 32'd5, 32'd9, "R6 R8 divisor larger");
    run_op(1, 0, 32'hFFFF_FFFF, 32'd1, "R6 max/1");
    run_op(1, 1, 32'hFFFF_FF8D, 32'd10, "R7 -115/10");
    run_op(1, 1, 32'd115, 32'hFFFF_FFF6, "R7 115/-10");
    run_op(1, 1, 32'hFFFF_FF8D, 32'hFFFF_FFF6, "R7 -115/-10");
    run_op(1, 1, 32'h8000_0000, 32'hFFFF_FFFF, "R8 signed overflow");
    run_op(1, 0, 32'd4242, 32'd0, "R9 unsigned div by zero");
    run_op(1, 1, 32'hFFFF_FC00, 32'd0, "R9 R8 signed div by zero");
    run_op(0, 0, 32'd7, 32'd9, "R10 mid start mul", 5);
    run_op(1, 1, 32'hFFFF_FF00, 32'd3, "R10 mid start div", 12);
    t_enable_low();
    t_reset_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule